// File: doc/BRIEF.md
# Frame Holding Register with Ready and Missed-Conversion Count

This block sits on the device side between a conversion engine that produces a fresh set of samples at a fixed, selectable rate and a serial read port. It owns one frame register. That register holds a header word followed by `NUM_WORDS` sample words. While streaming is enabled, an internal rate generator raises a conversion tick. On a tick, the samples on `conv_data` are captured, but only if the register is empty. If the register is not empty, the samples are dropped and a two-bit saturating missed-conversion count is incremented. The active-low `ready_n` output is low whenever a frame is held. It returns high only after the host has clocked out every word. Serial shifting is outside the block: each word read is presented to the block as one `rd_strobe` pulse.

The control state machine has four states. `ST_OFF` means streaming is disabled. `ST_EMPTY` means no frame is held. `ST_HELD` means a frame is held and not yet touched. `ST_DRAIN` means a frame is held and partly read.

The transitions are:
- **enable**: `ST_OFF` to `ST_EMPTY`.
- **load**: `ST_EMPTY` to `ST_HELD`, on a tick.
- **first read**: `ST_HELD` to `ST_DRAIN`, on a strobe.
- **complete**: `ST_DRAIN` to `ST_EMPTY`, on the strobe of the last word.
- **complete-and-reload**: `ST_DRAIN` to `ST_HELD`, on the last strobe with a tick in the same cycle.
- **disable**: any state to `ST_OFF` when `frame_en` is low.

The missed count is copied into the header when a frame is loaded, and it restarts from zero at that load. The header of the next frame therefore reports the gap that came before that frame. The header copy is cleared when its frame has been fully read.

Top module: `frame_hold_buf`

## Requirements
- R1: After reset, `ready_n` is 1 and `rd_word` is 0.
- R2: While `frame_en` is low, no frame is loaded, `ready_n` is 1, `rd_word` is 0 and `rd_strobe` is ignored. Lowering `frame_en` while a frame is held empties the register on the next edge, and it clears the read position and the missed count.
- R3: With `frame_en` high, the conversion tick repeats every D cycles. D is `64*BASE_DIV` for `rate_sel`=0, `8*BASE_DIV` for 1, `BASE_DIV` for 2, and `64*BASE_DIV` for 3. After `frame_en` rises, the first frame is loaded on the D-th rising edge at which `frame_en` is sampled high. `BASE_DIV` must be at least 2.
- R4: A tick loads `conv_data` only when the register is empty. While a frame is held, the stored words do not change, whatever `conv_data` and later ticks do.
- R5: `ready_n` falls on the edge that loads a frame. It stays low until the strobe for the last word, including after a partial read.
- R6: Reads are in this order: index 0 is the header, and index k+1 is sample word k, where word k is `conv_data[k*WORD_W +: WORD_W]` at load. Each `rd_strobe` advances one word. The word after the last one empties the register. Strobes while empty are ignored, and `rd_word` is 0 while empty.
- R7: The header word has bit `WORD_W-1` equal to 1 (the inverse of `ready_n`) and bits [1:0] equal to the missed count. All other bits are 0.
- R8: A tick that arrives while a frame is held, and is not on the completing strobe, adds 1 to the missed count, saturating at 3. The next loaded frame reports that count in its header, and the count restarts at 0 on that load.
- R9: If the last-word strobe and a tick fall in the same cycle, the new frame is loaded on that edge. `ready_n` stays low with no high cycle, and the new header carries the count accumulated up to then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_en | input | 1 | Streaming enable; low empties the register |
| rate_sel | input | 2 | Conversion rate select (0 slow, 1 mid, 2 fast, 3 slow) |
| conv_data | input | NUM_WORDS*WORD_W | Sample set offered at each tick |
| rd_strobe | input | 1 | One pulse per word clocked out by the host |
| rd_word | output | WORD_W | Word at the current read position |
| ready_n | output | 1 | Low while a frame is held |

## Verification
The bench targets the coincidence of the completing strobe with a tick. A design that passed through `ST_EMPTY` there would show a one-cycle high pulse on `ready_n`, or it would lose the new frame. It also sweeps the number of ticks missed while a frame is held, including the tick that falls mid-read. A counter that wraps instead of saturating, or that misses the mid-read tick, reports the wrong header value. Overwrite-on-hold is caught by changing `conv_data` while a frame is held and comparing the held words. A partial read followed by a disable catches a read position or count that survives the disable. A per-cycle reference model, built from the requirements, compares `ready_n` and `rd_word` on every cycle.

// File: rtl/fhb_pkg.sv
package fhb_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_EMPTY = 2'd1,
        ST_HELD  = 2'd2,
        ST_DRAIN = 2'd3
    } fhb_state_e;

    localparam logic [1:0] RATE_MID  = 2'd1;
    localparam logic [1:0] RATE_FAST = 2'd2;
    localparam logic [1:0] MISS_MAX  = 2'd3;
endpackage

// File: rtl/fhb_rate_gen.sv
module fhb_rate_gen
    import fhb_pkg::*;
#(
    parameter int BASE_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    localparam int CW = $clog2(BASE_DIV * 64);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (rate_sel)
            RATE_FAST: lim = CW'(BASE_DIV - 1);
            RATE_MID:  lim = CW'(BASE_DIV * 8 - 1);
            default:   lim = CW'(BASE_DIV * 64 - 1);
        endcase
        tick = en && (cnt_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R3: ticks are never back to back, since every divider is at least 2
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/fhb_miss_cnt.sv
module fhb_miss_cnt
    import fhb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       inc,
    output logic [1:0] cnt
);
    logic [1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (inc && cnt_q != MISS_MAX)
            cnt_q <= cnt_q + 2'd1;
    end

    assign cnt = cnt_q;

    // R8: once at the ceiling, further misses keep it there
    assert_miss_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MISS_MAX && inc && !clr) |=> (cnt_q == MISS_MAX));
    // R8: a miss below the ceiling always advances the count
    assert_miss_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != MISS_MAX && inc && !clr) |=> (cnt_q == $past(cnt_q) + 2'd1));
endmodule

// File: rtl/fhb_ctrl.sv
module fhb_ctrl
    import fhb_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    localparam int PW = $clog2(NUM_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_en,
    input  logic          conv_tick,
    input  logic          rd_strobe,
    output logic          ready_n,
    output logic          load,
    output logic          done,
    output logic          miss,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(NUM_WORDS);

    fhb_state_e    state_q, state_d;
    logic [PW-1:0] ptr_q, ptr_d;
    logic          held;

    assign held = (state_q == ST_HELD) || (state_q == ST_DRAIN);

    // next-state logic
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (!frame_en) begin
            state_d = ST_OFF;
            ptr_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_EMPTY;
                ST_EMPTY: if (conv_tick) state_d = ST_HELD;
                ST_HELD: begin
                    if (rd_strobe) begin
                        state_d = ST_DRAIN;
                        ptr_d   = ptr_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (rd_strobe) begin
                        if (ptr_q == LAST) begin
                            ptr_d   = '0;
                            state_d = conv_tick ? ST_HELD : ST_EMPTY;
                        end else begin
                            ptr_d = ptr_q + 1'b1;
                        end
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        ready_n = !held;
        done    = frame_en && (state_q == ST_DRAIN) && rd_strobe && (ptr_q == LAST);
        load    = frame_en && conv_tick && ((state_q == ST_EMPTY) || done);
        miss    = frame_en && conv_tick && held && !done;
        ptr     = ptr_q;
    end

    // R2: a low enable always leaves the register empty on the next cycle
    assert_off_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_en |=> ready_n);
    // R5: a held frame stays held until its last word is read
    assert_ready_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_n && frame_en && !done) |=> !ready_n);
    // R9: completion with a coincident tick leaves no high cycle on ready
    assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && conv_tick) |=> !ready_n);
    // R6: read position is zero whenever nothing is held
    assert_ptr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_n |-> (ptr_q == '0));
endmodule

// File: rtl/frame_hold_buf.sv
module frame_hold_buf
    import fhb_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 16,
    parameter int BASE_DIV  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_en,
    input  logic [1:0]                  rate_sel,
    input  logic [NUM_WORDS*WORD_W-1:0] conv_data,
    input  logic                        rd_strobe,
    output logic [WORD_W-1:0]           rd_word,
    output logic                        ready_n
);
    localparam int PW = $clog2(NUM_WORDS + 1);

    logic                              conv_tick;
    logic                              load, done, miss;
    logic [PW-1:0]                     ptr;
    logic [1:0]                        miss_cnt;
    logic [1:0]                        hdr_miss_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0]  data_q;
    logic [WORD_W-1:0]                 hdr_word;

    fhb_rate_gen #(.BASE_DIV(BASE_DIV)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (frame_en),
        .rate_sel (rate_sel),
        .tick     (conv_tick)
    );

    fhb_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_en  (frame_en),
        .conv_tick (conv_tick),
        .rd_strobe (rd_strobe),
        .ready_n   (ready_n),
        .load      (load),
        .done      (done),
        .miss      (miss),
        .ptr       (ptr)
    );

    fhb_miss_cnt u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load || !frame_en),
        .inc   (miss),
        .cnt   (miss_cnt)
    );

    // header copy of the missed count
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_en)
            hdr_miss_q <= '0;
        else if (load)
            hdr_miss_q <= miss_cnt;
        else if (done)
            hdr_miss_q <= '0;
    end

    // sample word storage, one lane per word
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[g] <= '0;
            else if (load)
                data_q[g] <= conv_data[g*WORD_W +: WORD_W];
        end
    end

    assign hdr_word = {1'b1, {(WORD_W-3){1'b0}}, hdr_miss_q};

    always_comb begin
        rd_word = '0;
        if (!ready_n) begin
            if (ptr == '0)
                rd_word = hdr_word;
            else
                for (int i = 0; i < NUM_WORDS; i++)
                    if (ptr == PW'(i + 1))
                        rd_word = data_q[i];
        end
    end

    // R4: held samples are never overwritten
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_n && frame_en && !done) |=> $stable(data_q));
    // R8: the header count is zero after a completed read with no reload
    assert_hdr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> (hdr_miss_q == 2'd0));
endmodule

// File: tb/frame_hold_buf_bench.sv
module frame_hold_buf_bench;
    localparam int NW = 4;
    localparam int W  = 16;
    localparam int BD = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_en = 1'b0;
    logic [1:0]        rate_sel = 2'd2;
    logic [NW*W-1:0]   conv_data = '0;
    logic              rd_strobe = 1'b0;
    logic [W-1:0]      rd_word;
    logic              ready_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    frame_hold_buf #(.NUM_WORDS(NW), .WORD_W(W), .BASE_DIV(BD)) u_frame_hold_buf (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .rate_sel(rate_sel),
        .conv_data(conv_data), .rd_strobe(rd_strobe), .rd_word(rd_word), .ready_n(ready_n)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int div_of(input logic [1:0] s);
        return (s == 2'd2) ? BD : (s == 2'd1) ? BD * 8 : BD * 64;
    endfunction

    function automatic logic [W-1:0] hdr(input int m);
        return {1'b1, {(W-3){1'b0}}, 2'(m)};
    endfunction

    function automatic logic [NW*W-1:0] pat(input int seed);
        logic [NW*W-1:0] v;
        for (int k = 0; k < NW; k++) v[k*W +: W] = W'(seed * 16'h1111 + k * 16'h0203 + 16'h0100);
        return v;
    endfunction

    // reference model built from the requirements
    int m_cnt = 0, m_ptr = 0, m_miss = 0, m_hovf = 0;
    bit m_full = 1'b0;
    logic [NW*W-1:0] m_data = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n || !frame_en) begin
            m_cnt = 0; m_ptr = 0; m_miss = 0; m_hovf = 0; m_full = 1'b0;
        end else begin
            bit tk, dn;
            tk = (m_cnt >= div_of(rate_sel) - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            dn = m_full && rd_strobe && (m_ptr == NW);
            if (m_full && rd_strobe) begin
                if (dn) begin m_full = 1'b0; m_ptr = 0; m_hovf = 0; end
                else m_ptr++;
            end
            if (tk) begin
                if (!m_full) begin
                    m_full = 1'b1; m_data = conv_data; m_hovf = m_miss; m_miss = 0;
                end else if (m_miss < 3) m_miss++;
            end
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            logic [W-1:0] e;
            check("R5", {{(W-1){1'b0}}, ready_n}, {{(W-1){1'b0}}, !m_full});
            e = !m_full ? '0 : (m_ptr == 0) ? hdr(m_hovf) : m_data[(m_ptr-1)*W +: W];
            check((m_ptr == 0) ? "R7" : "R6", rd_word, e);
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_load(output int lat);
        lat = 0;
        while (ready_n === 1'b1 && lat < 2000) begin @(negedge clk); lat++; end
    endtask

    // reads a whole frame from the current negedge, checking each word
    task automatic read_frame(input string req, input int miss_exp, input logic [NW*W-1:0] d);
        for (int i = 0; i <= NW; i++) begin
            check(req, rd_word, (i == 0) ? hdr(miss_exp) : d[(i-1)*W +: W]);
            check("R5", {{(W-1){1'b0}}, ready_n}, '0);
            rd_strobe = 1'b1;
            @(negedge clk);
        end
        rd_strobe = 1'b0;
    endtask

    task automatic restart(input logic [1:0] s, input logic [NW*W-1:0] d);
        frame_en = 1'b0;
        wait_cyc(2);
        rate_sel = s; conv_data = d; frame_en = 1'b1;
    endtask

    initial begin
        int lat;
        wait_cyc(3);
        check("R1", {{(W-1){1'b0}}, ready_n}, 16'd1);
        check("R1", rd_word, '0);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R2: disabled, strobes ignored
        conv_data = pat(1);
        for (int i = 0; i < 300; i++) begin
            rd_strobe = i[0];
            @(negedge clk);
            if (ready_n !== 1'b1 || rd_word !== '0) begin
                check("R2", {rd_word[W-2:0], ready_n}, 16'd1);
                break;
            end
        end
        rd_strobe = 1'b0;
        check("R2", {{(W-1){1'b0}}, ready_n}, 16'd1);

        // R3: first-load latency for every rate setting, then a full read
        for (int s = 0; s < 4; s++) begin
            restart(2'(s), pat(s + 2));
            wait_load(lat);
            check("R3", 16'(lat), 16'(div_of(2'(s))));
            conv_data = pat(s + 20);
            if (s != 2) read_frame("R6", 0, pat(s + 2));
        end

        // R4/R8: sweep of ticks missed while a frame is held
        for (int m = 0; m < 6; m++) begin
            restart(2'd2, pat(40 + m));
            wait_load(lat);
            conv_data = pat(60 + m);
            wait_cyc(4 * m);
            read_frame("R4", 0, pat(40 + m));
            wait_load(lat);
            read_frame("R8", (m + 1 > 3) ? 3 : m + 1, pat(60 + m));
        end

        // R5: partial read keeps the frame and the position
        restart(2'd0, pat(80));
        wait_load(lat);
        rd_strobe = 1'b1; wait_cyc(2); rd_strobe = 1'b0;
        wait_cyc(20);
        check("R5", {{(W-1){1'b0}}, ready_n}, '0);
        check("R5", rd_word, pat(80)[W +: W]);

        // R2: disable mid-frame after misses, then re-enable
        restart(2'd2, pat(81));
        wait_load(lat);
        wait_cyc(10);
        rd_strobe = 1'b1; wait_cyc(2); rd_strobe = 1'b0;
        frame_en = 1'b0;
        wait_cyc(1);
        check("R2", {{(W-1){1'b0}}, ready_n}, 16'd1);
        check("R2", rd_word, '0);
        conv_data = pat(82); frame_en = 1'b1;
        wait_load(lat);
        read_frame("R2", 0, pat(82));

        // R6: strobes while empty are ignored
        restart(2'd1, pat(83));
        wait_load(lat);
        read_frame("R6", 0, pat(83));
        rd_strobe = 1'b1; wait_cyc(3); rd_strobe = 1'b0;
        check("R6", rd_word, '0);
        wait_load(lat);
        read_frame("R6", 0, pat(83));

        // R9: last strobe coincides with a tick
        restart(2'd2, pat(90));
        wait_load(lat);
        conv_data = pat(91);
        wait_cyc(3);
        read_frame("R9", 0, pat(90));
        check("R9", {{(W-1){1'b0}}, ready_n}, '0);
        read_frame("R9", 1, pat(91));

        frame_en = 1'b0;
        wait_cyc(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule